// File: doc/BRIEF.md
# Flash Lock and Protection Manager

This block holds the write-protection state of a flash command interface. It keeps one lock bit per erase block, a master lock that freezes those bits, and a small one-time-programmable protection area of 18 bytes. Commands reach it as byte writes (`wr_en`, `wr_addr`, `wr_data`). A first write arms either lock configuration (`0x60`) or protection programming (`0xC0`). The second write carries a subcode or data, is checked against the lock state, and either updates state or records a refusal in the status byte. After every second cycle the interface is left in status-read mode.

A `hard_unlock` input stands for a high-voltage level on the reset pin. It is the only way to set the master lock. While it is high it also overrides the master lock. The lock vector and the master lock are exported as plain outputs. The protection bytes are read through an asynchronous read port indexed from 0.

Top module: `flash_lock_mgr`

## Requirements
- R1: After reset the status is `0x80`, the status-mode flag is 0, every block lock and the master lock are 0, and the protection bytes read `0xFF` except byte 0, which reads `0xFE`. Bit 0 of protection byte 0 is never 1.
- R2: Writing `0x60` and then subcode `0x01` sets the lock bit of the block selected by `wr_addr[22:17]`, with a 128 KiB block size. Block locks change only on the clock edge after a write.
- R3: Writing `0x60` and then subcode `0xD0` clears the lock bit of the addressed block.
- R4: Subcode `0xF1` sets the master lock only while `hard_unlock` is 1. Without `hard_unlock` it ORs `0x12` into the status and leaves the master lock unchanged.
- R5: While the master lock is 1 and `hard_unlock` is 0, subcode `0x01` ORs `0x12` into the status and subcode `0xD0` ORs `0x22` into it, and the lock vector stays unchanged. With `hard_unlock` at 1, both subcodes take effect.
- R6: Subcode `0x03` changes nothing. Any subcode other than `0x01`, `0x03`, `0xD0` or `0xF1` ORs `0x30` into the status.
- R7: Writing `0xC0` and then a write to a byte address in `0x100..0x111` ANDs the data into protection byte (address − `0x100`). A second write outside that window ORs `0x10` into the status and changes no byte. Protection bits only ever go from 1 to 0.
- R8: A protection byte with index 2 or above is writable only while bit ((index − 2) >> 3) of protection byte 0 is 1. Otherwise the write ORs `0x12` into the status and the byte is unchanged. Indexes 0 and 1 are always writable.
- R9: Each arming write (`0x60` or `0xC0`) clears status bits 5, 4, 3 and 1 (status AND `0xC5`). Status bit 7 (ready) is always 1.
- R10: The second cycle of either command sets the status-mode flag. A first-cycle write of `0xFF` clears it. Any other first-cycle value has no effect.
- R11: Once set, the master lock clears only through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command/data write strobe, one cycle per write |
| wr_addr | input | 23 | Byte address of the write |
| wr_data | input | 8 | Command, subcode or protection data |
| hard_unlock | input | 1 | High-voltage override of the locks |
| lock_vec | output | 64 | Per-block lock bits, bit n for block n |
| master_lock | output | 1 | Master lock state |
| status | output | 8 | Status byte |
| status_mode | output | 1 | 1 when reads should return status |
| prot_raddr | input | 5 | Protection byte read index |
| prot_rdata | output | 8 | Protection byte at `prot_raddr` (`0xFF` beyond byte 17) |

## Verification
The hardest state to reach is a protection write into the second segment after that segment has been closed. Reaching it takes two successful AND writes in order: first a byte at index 10 or above, then byte 0 with bit 1 cleared. Only after both does a refusal become observable. The directed part of the bench walks this sequence. The random part draws second-cycle addresses around the window edges, so writes to byte 0 are frequent enough to close segments in varying orders. Random subcodes, taken while the master lock is set both with and without `hard_unlock`, cover the override paths.

// File: rtl/flm_pkg.sv
package flm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOCK = 2'd1,
    ST_PROT = 2'd2
  } cmd_st_e;

  localparam logic [7:0] CMD_LOCKCFG = 8'h60;
  localparam logic [7:0] CMD_PROTPGM = 8'hC0;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;

  localparam logic [7:0] SUB_MASTER  = 8'hF1;
  localparam logic [7:0] SUB_SETBLK  = 8'h01;
  localparam logic [7:0] SUB_CLRBLK  = 8'hD0;
  localparam logic [7:0] SUB_NOP     = 8'h03;

  localparam logic [7:0] STAT_RESET  = 8'h80;
  localparam logic [7:0] STAT_KEEP   = 8'hC5;
  localparam logic [7:0] ERR_PERM    = 8'h12;
  localparam logic [7:0] ERR_UNLOCK  = 8'h22;
  localparam logic [7:0] ERR_SEQ     = 8'h30;
  localparam logic [7:0] ERR_RANGE   = 8'h10;
endpackage

// File: rtl/flm_rst_sync.sv
module flm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/flm_cmd_fsm.sv
module flm_cmd_fsm
  import flm_pkg::*;
#(
  parameter int ADDR_W     = 23,
  parameter int BLK_SHIFT  = 17,
  parameter int PROT_BASE  = 256,
  parameter int PROT_BYTES = 18,
  localparam int BLK_W     = ADDR_W - BLK_SHIFT,
  localparam int IDX_W     = $clog2(PROT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hard_unlock,
  input  logic              master_lock,
  input  logic [7:0]        prot_ctl,
  output logic              set_master,
  output logic              set_blk,
  output logic              clr_blk,
  output logic [BLK_W-1:0]  blk_idx,
  output logic              prot_we,
  output logic [IDX_W-1:0]  prot_idx,
  output logic [7:0]        status,
  output logic              status_mode
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(PROT_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(PROT_BASE + PROT_BYTES);
  localparam logic [IDX_W-1:0]  IDX_LO = IDX_W'(PROT_BASE);
  localparam logic [IDX_W-1:0]  FIRST_GATED = IDX_W'(2);

  cmd_st_e    st_q, st_d;
  logic [7:0] stat_q, stat_d;
  logic       mode_q, mode_d;

  logic             frozen;
  logic             in_win;
  logic [IDX_W-1:0] rel_idx;
  logic [IDX_W-1:0] rel_m2;
  logic             seg_open;

  assign blk_idx  = wr_addr[ADDR_W-1:BLK_SHIFT];
  assign frozen   = master_lock && !hard_unlock;
  assign in_win   = (wr_addr >= WIN_LO) && (wr_addr < WIN_HI);
  assign rel_idx  = wr_addr[IDX_W-1:0] - IDX_LO;
  assign rel_m2   = rel_idx - FIRST_GATED;
  assign seg_open = (rel_idx < FIRST_GATED) || prot_ctl[rel_m2[IDX_W-1:3]];
  assign prot_idx = rel_idx;

  always_comb begin
    st_d       = st_q;
    stat_d     = stat_q;
    mode_d     = mode_q;
    set_master = 1'b0;
    set_blk    = 1'b0;
    clr_blk    = 1'b0;
    prot_we    = 1'b0;
    if (wr_en) begin
      unique case (st_q)
        ST_IDLE: begin
          if (wr_data == CMD_LOCKCFG) begin
            st_d   = ST_LOCK;
            stat_d = stat_q & STAT_KEEP;
          end else if (wr_data == CMD_PROTPGM) begin
            st_d   = ST_PROT;
            stat_d = stat_q & STAT_KEEP;
          end else if (wr_data == CMD_ARRAY) begin
            mode_d = 1'b0;
          end
        end
        ST_LOCK: begin
          st_d   = ST_IDLE;
          mode_d = 1'b1;
          case (wr_data)
            SUB_MASTER: begin
              if (hard_unlock) set_master = 1'b1;
              else             stat_d = stat_q | ERR_PERM;
            end
            SUB_SETBLK: begin
              if (frozen) stat_d  = stat_q | ERR_PERM;
              else        set_blk = 1'b1;
            end
            SUB_CLRBLK: begin
              if (frozen) stat_d  = stat_q | ERR_UNLOCK;
              else        clr_blk = 1'b1;
            end
            SUB_NOP: ;
            default: stat_d = stat_q | ERR_SEQ;
          endcase
        end
        ST_PROT: begin
          st_d   = ST_IDLE;
          mode_d = 1'b1;
          if (!in_win)        stat_d  = stat_q | ERR_RANGE;
          else if (!seg_open) stat_d  = stat_q | ERR_PERM;
          else                prot_we = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stat_q <= STAT_RESET;
      mode_q <= 1'b0;
    end else if (wr_en) begin
      st_q   <= st_d;
      stat_q <= stat_d;
      mode_q <= mode_d;
    end
  end

  assign status      = stat_q;
  assign status_mode = mode_q;
endmodule

// File: rtl/flm_lock_bank.sv
module flm_lock_bank #(
  parameter int  BLK_W = 6,
  localparam int N_BLK = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_master,
  input  logic             set_blk,
  input  logic             clr_blk,
  input  logic [BLK_W-1:0] blk_idx,
  output logic [N_BLK-1:0] lock_vec,
  output logic             master_lock
);
  logic master_q;

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    logic hit;
    logic lk_q;
    assign hit = (set_blk || clr_blk) && (blk_idx == BLK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lk_q <= 1'b0;
      else if (hit) lk_q <= set_blk;
    end
    assign lock_vec[b] = lk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          master_q <= 1'b0;
    else if (set_master) master_q <= 1'b1;
  end

  assign master_lock = master_q;
endmodule

// File: rtl/flm_prot_store.sv
module flm_prot_store #(
  parameter int  PROT_BYTES = 18,
  localparam int IDX_W      = $clog2(PROT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata,
  output logic [7:0]       ctl
);
  logic [7:0] mem [PROT_BYTES];

  for (genvar i = 0; i < PROT_BYTES; i++) begin : g_byte
    localparam logic [7:0] INIT = (i == 0) ? 8'hFE : 8'hFF;
    logic en;
    assign en = we && (widx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem[i] <= INIT;
      else if (en) mem[i] <= mem[i] & wdata;
    end
  end

  always_comb begin
    rdata = 8'hFF;
    for (int i = 0; i < PROT_BYTES; i++) begin
      if (raddr == IDX_W'(i)) rdata = mem[i];
    end
  end

  assign ctl = mem[0];
endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr #(
  parameter int  ADDR_W     = 23,
  parameter int  BLK_SHIFT  = 17,
  parameter int  PROT_BASE  = 256,
  parameter int  PROT_BYTES = 18,
  localparam int BLK_W      = ADDR_W - BLK_SHIFT,
  localparam int N_BLK      = 1 << BLK_W,
  localparam int IDX_W      = $clog2(PROT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hard_unlock,
  output logic [N_BLK-1:0]  lock_vec,
  output logic              master_lock,
  output logic [7:0]        status,
  output logic              status_mode,
  input  logic [IDX_W-1:0]  prot_raddr,
  output logic [7:0]        prot_rdata
);
  logic             rst_n_s;
  logic             set_master, set_blk, clr_blk, prot_we;
  logic [BLK_W-1:0] blk_idx;
  logic [IDX_W-1:0] prot_idx;
  logic [7:0]       prot_ctl;

  flm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  flm_cmd_fsm #(
    .ADDR_W     (ADDR_W),
    .BLK_SHIFT  (BLK_SHIFT),
    .PROT_BASE  (PROT_BASE),
    .PROT_BYTES (PROT_BYTES)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .hard_unlock (hard_unlock),
    .master_lock (master_lock),
    .prot_ctl    (prot_ctl),
    .set_master  (set_master),
    .set_blk     (set_blk),
    .clr_blk     (clr_blk),
    .blk_idx     (blk_idx),
    .prot_we     (prot_we),
    .prot_idx    (prot_idx),
    .status      (status),
    .status_mode (status_mode)
  );

  flm_lock_bank #(.BLK_W(BLK_W)) u_locks (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .set_master  (set_master),
    .set_blk     (set_blk),
    .clr_blk     (clr_blk),
    .blk_idx     (blk_idx),
    .lock_vec    (lock_vec),
    .master_lock (master_lock)
  );

  flm_prot_store #(.PROT_BYTES(PROT_BYTES)) u_prot (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (prot_we),
    .widx  (prot_idx),
    .wdata (wr_data),
    .raddr (prot_raddr),
    .rdata (prot_rdata),
    .ctl   (prot_ctl)
  );
endmodule

// File: rtl/flm_checker.sv
module flm_checker #(
  parameter int N_BLK = 64,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             hard_unlock,
  input logic             master_lock,
  input logic [N_BLK-1:0] lock_vec,
  input logic [7:0]       status,
  input logic [IDX_W-1:0] prot_raddr,
  input logic [7:0]       prot_rdata
);
  // R11
  master_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(master_lock));

  // R4
  master_needs_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_lock) |-> $past(wr_en && hard_unlock));

  // R9
  ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7]);

  // R1
  factory_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_raddr == '0) |-> !prot_rdata[0]);

  // R7
  prot_and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(prot_raddr) |-> ((prot_rdata & ~$past(prot_rdata)) == 8'h00));

  // R2
  lock_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(lock_vec));

  // R5
  frozen_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && master_lock && !hard_unlock) |-> $stable(lock_vec));
endmodule

bind flash_lock_mgr flm_checker #(.N_BLK(N_BLK), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .hard_unlock (hard_unlock),
  .master_lock (master_lock),
  .lock_vec    (lock_vec),
  .status      (status),
  .prot_raddr  (prot_raddr),
  .prot_rdata  (prot_rdata)
);

// File: tb/test_flash_lock_mgr.sv
`timescale 1ns/1ps
module test_flash_lock_mgr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [22:0] wr_addr;
  logic [7:0]  wr_data;
  logic        hard_unlock;
  logic [63:0] lock_vec;
  logic        master_lock;
  logic [7:0]  status;
  logic        status_mode;
  logic [4:0]  prot_raddr;
  logic [7:0]  prot_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // expected state, kept from the requirements
  logic [63:0] e_lk;
  logic        e_ml;
  logic [7:0]  e_st;
  logic        e_mode;
  logic [7:0]  e_pr [18];
  int          e_arm;   // 0 idle, 1 lock armed, 2 protection armed

  always #2.5 clk = ~clk;

  flash_lock_mgr i_flash_lock_mgr (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .hard_unlock,
    .lock_vec, .master_lock, .status, .status_mode, .prot_raddr, .prot_rdata
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    e_lk = '0; e_ml = 1'b0; e_st = 8'h80; e_mode = 1'b0; e_arm = 0;
    for (int i = 0; i < 18; i++) e_pr[i] = (i == 0) ? 8'hFE : 8'hFF;
  endtask

  function automatic bit seg_open(input int idx);
    if (idx < 2) return 1'b1;
    return e_pr[0][(idx - 2) >> 3];
  endfunction

  task automatic model_write(input logic [22:0] a, input logic [7:0] d);
    int b, off;
    bit frz;
    b   = int'(a[22:17]);
    frz = e_ml && !hard_unlock;
    case (e_arm)
      0: begin
        if (d == 8'h60)      begin e_arm = 1; e_st = e_st & 8'hC5; end
        else if (d == 8'hC0) begin e_arm = 2; e_st = e_st & 8'hC5; end
        else if (d == 8'hFF) e_mode = 1'b0;
      end
      1: begin
        e_arm = 0; e_mode = 1'b1;
        case (d)
          8'hF1: if (hard_unlock) e_ml = 1'b1; else e_st = e_st | 8'h12;
          8'h01: if (frz) e_st = e_st | 8'h12; else e_lk[b] = 1'b1;
          8'hD0: if (frz) e_st = e_st | 8'h22; else e_lk[b] = 1'b0;
          8'h03: ;
          default: e_st = e_st | 8'h30;
        endcase
      end
      default: begin
        e_arm = 0; e_mode = 1'b1;
        if (a < 23'h100 || a >= 23'h112) e_st = e_st | 8'h10;
        else begin
          off = int'(a) - 256;
          if (!seg_open(off)) e_st = e_st | 8'h12;
          else e_pr[off] = e_pr[off] & d;
        end
      end
    endcase
  endtask

  task automatic bus_write(input logic [22:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string req);
    check(req, "lock_vec", lock_vec, e_lk);
    check("R11", "master_lock", {63'b0, master_lock}, {63'b0, e_ml});
    check("R9", "status", {56'b0, status}, {56'b0, e_st});
    check("R10", "status_mode", {63'b0, status_mode}, {63'b0, e_mode});
    for (int i = 0; i < 18; i++) begin
      prot_raddr = 5'(i);
      #0.1;
      check("R7", $sformatf("prot[%0d]", i), {56'b0, prot_rdata}, {56'b0, e_pr[i]});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    hard_unlock = 1'b0; prot_raddr = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_all("R1");
    check("R1", "status literal", {56'b0, status}, 64'h80);
    prot_raddr = 5'd0; #0.1;
    check("R1", "prot byte0 literal", {56'b0, prot_rdata}, 64'hFE);

    // R2 set lock of block 5, R10 status mode
    bus_write(23'h0A_0000 | 23'h123, 8'h60);
    check("R9", "arm keeps status", {56'b0, status}, 64'h80);
    bus_write(23'h0A_0000 | 23'h123, 8'h01);
    check("R2", "block5 set", lock_vec, 64'h20);
    check("R10", "status mode set", {63'b0, status_mode}, 64'h1);
    check_all("R2");

    // R3 clear lock of block 5
    bus_write(23'h0A_0000, 8'h60);
    bus_write(23'h0B_FFFF, 8'hD0);
    check("R3", "block5 cleared", lock_vec, 64'h0);
    bus_write(23'h7E_0000, 8'h60);
    bus_write(23'h7E_0000, 8'h01);
    check_all("R3");

    // R4 master lock without and with high voltage
    bus_write(0, 8'h60);
    bus_write(0, 8'hF1);
    check("R4", "master refused status", {56'b0, status}, 64'h92);
    check("R4", "master still clear", {63'b0, master_lock}, 64'h0);
    hard_unlock = 1'b1;
    bus_write(0, 8'h60);
    bus_write(0, 8'hF1);
    check("R4", "master set", {63'b0, master_lock}, 64'h1);
    check("R9", "arm cleared error", {56'b0, status}, 64'h80);
    hard_unlock = 1'b0;

    // R5 master lock freezes block locks
    bus_write(23'h02_0000, 8'h60);
    bus_write(23'h02_0000, 8'h01);
    check("R5", "frozen set status", {56'b0, status}, 64'h92);
    bus_write(23'h7E_0000, 8'h60);
    bus_write(23'h7E_0000, 8'hD0);
    check("R5", "frozen clear status", {56'b0, status}, 64'hA2);
    check("R5", "frozen vector", lock_vec, 64'h8000_0000_0000_0000);
    hard_unlock = 1'b1;
    bus_write(23'h02_0000, 8'h60);
    bus_write(23'h02_0000, 8'h01);
    check("R5", "override set", lock_vec, 64'h8000_0000_0000_0002);
    hard_unlock = 1'b0;
    check_all("R5");

    // R6 ignored and unknown subcodes
    bus_write(0, 8'h60);
    bus_write(0, 8'h03);
    check("R6", "nop status", {56'b0, status}, 64'h80);
    bus_write(0, 8'h60);
    bus_write(0, 8'h55);
    check("R6", "unknown status", {56'b0, status}, 64'hB0);
    check_all("R6");

    // R7 protection writes, window edges
    bus_write(23'h101, 8'hC0);
    bus_write(23'h101, 8'hA5);
    prot_raddr = 5'd1; #0.1;
    check("R7", "byte1 anded", {56'b0, prot_rdata}, 64'hA5);
    bus_write(23'h112, 8'hC0);
    bus_write(23'h112, 8'h00);
    check("R7", "above window", {56'b0, status}, 64'h90);
    bus_write(23'h0FF, 8'hC0);
    bus_write(23'h0FF, 8'h00);
    check_all("R7");

    // R8 segment gating by byte 0
    bus_write(23'h105, 8'hC0);
    bus_write(23'h105, 8'h00);
    check("R8", "factory segment refused", {56'b0, status}, 64'h92);
    bus_write(23'h10C, 8'hC0);
    bus_write(23'h10C, 8'h3C);
    prot_raddr = 5'd12; #0.1;
    check("R8", "open segment written", {56'b0, prot_rdata}, 64'h3C);
    bus_write(23'h100, 8'hC0);
    bus_write(23'h100, 8'hFD);
    bus_write(23'h10C, 8'hC0);
    bus_write(23'h10C, 8'h00);
    prot_raddr = 5'd12; #0.1;
    check("R8", "closed segment kept", {56'b0, prot_rdata}, 64'h3C);
    check("R8", "closed segment status", {56'b0, status}, 64'h92);
    check_all("R8");

    // R10 read-array command clears mode, others ignored
    bus_write(0, 8'h12);
    check("R10", "stray keeps mode", {63'b0, status_mode}, 64'h1);
    bus_write(0, 8'hFF);
    check("R10", "array clears mode", {63'b0, status_mode}, 64'h0);
    check_all("R10");

    // R11 master survives override writes, clears on reset
    hard_unlock = 1'b1;
    bus_write(0, 8'h60);
    bus_write(0, 8'hD0);
    hard_unlock = 1'b0;
    check("R11", "master kept", {63'b0, master_lock}, 64'h1);
    do_reset();
    check_all("R1");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int kind;
      logic [22:0] a;
      logic [7:0]  d;
      kind = int'($urandom_range(0, 9));
      hard_unlock = ($urandom_range(0, 3) == 0);
      if (kind < 4) begin
        a = {3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 17'($urandom)};
        case ($urandom_range(0, 5))
          0: d = 8'hF1;
          1, 2: d = 8'h01;
          3: d = 8'hD0;
          4: d = 8'h03;
          default: d = 8'($urandom);
        endcase
        bus_write(a, 8'h60);
        bus_write(a, d);
        check_all("R2");
      end else if (kind < 8) begin
        a = 23'($urandom_range(32'hFC, 32'h115));
        d = ($urandom_range(0, 2) == 0) ? 8'($urandom) : ~(8'h1 << $urandom_range(0, 7));
        bus_write(a, 8'hC0);
        bus_write(a, d);
        check_all("R8");
      end else begin
        d = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
        if (d == 8'h60 || d == 8'hC0) d = 8'h70;
        bus_write(23'($urandom), d);
        check_all("R10");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule